// File: doc/BRIEF.md
# Command Frame Parser for a Search Accelerator

This block sits behind a raw Ethernet receiver. It turns a stream of fixed-size command frames into actions for a string-search engine. Bytes arrive one per cycle with a valid strobe, an end-of-frame marker and a frame-good flag. The parser checks the header: it requires a broadcast destination and the expected protocol word, and it reads a 16-bit command type. The type then decides what happens to the payload. The payload can be dropped, written as a zero-terminated search string, or appended as 16-bit words to a database memory. Each database word also goes into a running checksum.

Control frames produce single-cycle pulses:
- a reset, which clears the database pointer and the checksum;
- a checksum report, which carries the current sum;
- a start command.

A frame is 1024 bytes long and is followed by four check bytes, which the parser never stores. A frame that is bad, malformed or short leaves all state untouched. All outputs are registered, and the write ports feed memories that can be inferred as block RAM.

Top module: `cmd_frame_parser`

## Requirements
- R1: A frame is acted on only if it meets all of the following:
  - `in_good` is high with its byte 0;
  - bytes 0 to 5 are all 0xFF;
  - bytes 12 (high) and 13 (low) equal 0x8000;
  - it reaches byte 13.
  
  Otherwise it causes no write, no pulse and no state change. Bytes 6 to 9 are never examined.
- R2: The type is formed as {byte 10, byte 11}. Type 0x0000 gives a one-cycle `rst_pulse`, sets the next database address to 0 and clears the checksum. Its payload is discarded.
- R3: Type 0xAAAA gives a one-cycle `ck_req`. With it, `ck_value` equals the 16-bit truncated sum of all database words written since the last reset. `ck_value` changes only while `ck_req` is high.
- R4: Type 0xCCCC gives a one-cycle `go_pulse` and discards its payload.
- R5: Type 0xBBBB writes payload bytes to `ss_addr` 0, 1, 2 and so on, up to and including the first zero byte. Nothing is written after that byte.
- R6: If search-string bytes reach address 255, that address receives 0 instead of the byte, and writing stops.
- R7: Any other type pairs the payload bytes into words. The byte at an even frame offset is the most significant. Each word is written to `db_addr`, which continues consecutively from the previous data frame.
- R8: Bytes at frame offset 1024 and above are never stored or summed. A frame that ends with an unpaired payload byte drops that byte.
- R9: A frame whose `in_good` is low on byte 0 is consumed with no effect on any output or on later results.
- R10: After `rst`, every pulse and write strobe is low, `ck_value` is 0, and the first database write goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_good | input | 1 | Receiver status for the frame, sampled with byte 0 |
| rst_pulse | output | 1 | Reset command pulse |
| ck_req | output | 1 | Checksum report pulse |
| ck_value | output | 16 | Checksum reported with `ck_req` |
| go_pulse | output | 1 | Start command pulse |
| ss_we | output | 1 | Search-string write strobe |
| ss_addr | output | SS_AW | Search-string write address |
| ss_data | output | 8 | Search-string write byte |
| db_we | output | 1 | Database write strobe |
| db_addr | output | DB_AW | Database write address |
| db_data | output | 16 | Database write word |

## Verification
Most internal faults surface on the write ports within one or two cycles.

A byte counter that is off by one shows up as words with swapped or shifted bytes on the first database write of the frame. It can also show up as an extra word built from the trailing check bytes, around byte 1025.

A header decision taken on the wrong conditions shows up as writes or pulses during a frame that should have been ignored.

A broken write pointer shows up as an address break on the first write of the next data frame. A corrupted checksum stays hidden until the next report frame, so report frames are interleaved with data, bad and reset frames.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int HDR_BYTES = 14;
  localparam int TYPE_HI   = 10;
  localparam int TYPE_LO   = 11;
  localparam int PROTO_HI  = 12;
  localparam int DST_LAST  = 5;
  localparam logic [15:0] PROTO_ID  = 16'h8000;
  localparam logic [15:0] CODE_RST  = 16'h0000;
  localparam logic [15:0] CODE_CKR  = 16'hAAAA;
  localparam logic [15:0] CODE_SSTR = 16'hBBBB;
  localparam logic [15:0] CODE_GO   = 16'hCCCC;

  typedef enum logic [2:0] {
    CMD_RST, CMD_CKREP, CMD_SSTR, CMD_GO, CMD_DATA
  } cmd_t;

  typedef enum logic [1:0] {
    PM_NONE, PM_SSTR, PM_DATA
  } pay_mode_t;

  function automatic cmd_t decode_type(input logic [15:0] code);
    case (code)
      CODE_RST:  return CMD_RST;
      CODE_CKR:  return CMD_CKREP;
      CODE_SSTR: return CMD_SSTR;
      CODE_GO:   return CMD_GO;
      default:   return CMD_DATA;
    endcase
  endfunction
endpackage

// File: rtl/cfp_hdr.sv
module cfp_hdr import cfp_pkg::*; #(
  parameter int FRAME_LEN = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_good,
  output logic       hdr_fire,
  output cmd_t       hdr_cmd,
  output logic       pay_valid,
  output logic       pay_msb,
  output pay_mode_t  pay_mode,
  output logic       frame_end
);
  localparam int POS_W = $clog2(FRAME_LEN) + 2;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos;
  logic             ok_q, bcast_q;
  logic [15:0]      type_q;
  logic [7:0]       proto_hi_q;
  pay_mode_t        mode_q;

  logic at_end_of_hdr, accept;
  assign at_end_of_hdr = in_valid && (pos == POS_W'(HDR_BYTES - 1));
  assign accept   = ok_q && bcast_q && ({proto_hi_q, in_data} == PROTO_ID);
  assign hdr_fire = at_end_of_hdr && accept;
  assign hdr_cmd  = decode_type(type_q);
  assign frame_end = in_valid && in_last;
  assign pay_mode  = mode_q;
  assign pay_msb   = ~pos[0];
  assign pay_valid = in_valid && (mode_q != PM_NONE) &&
                     (pos >= POS_W'(HDR_BYTES)) && (pos < POS_W'(FRAME_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos        <= '0;
      ok_q       <= 1'b0;
      bcast_q    <= 1'b0;
      type_q     <= '0;
      proto_hi_q <= '0;
      mode_q     <= PM_NONE;
    end else if (in_valid) begin
      if (in_last)             pos <= '0;
      else if (pos != POS_MAX) pos <= pos + 1'b1;

      if (pos == '0) begin
        ok_q    <= in_good;
        bcast_q <= (in_data == 8'hFF);
      end else if (pos <= POS_W'(DST_LAST)) begin
        bcast_q <= bcast_q && (in_data == 8'hFF);
      end
      if (pos == POS_W'(TYPE_HI))  type_q[15:8] <= in_data;
      if (pos == POS_W'(TYPE_LO))  type_q[7:0]  <= in_data;
      if (pos == POS_W'(PROTO_HI)) proto_hi_q   <= in_data;

      if (in_last)
        mode_q <= PM_NONE;
      else if (hdr_fire)
        mode_q <= (hdr_cmd == CMD_SSTR) ? PM_SSTR :
                  (hdr_cmd == CMD_DATA) ? PM_DATA : PM_NONE;
    end
  end
endmodule

// File: rtl/cfp_sum.sv
module cfp_sum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         word_v,
  input  logic [W-1:0] word,
  output logic [W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (rst || clr)  sum <= '0;
    else if (word_v) sum <= sum + word;
  end
endmodule

// File: rtl/cfp_pay.sv
module cfp_pay import cfp_pkg::*; #(
  parameter int DB_AW = 16,
  parameter int SS_AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_fire,
  input  cmd_t             hdr_cmd,
  input  logic             pay_valid,
  input  logic             pay_msb,
  input  logic [7:0]       pay_data,
  input  pay_mode_t        pay_mode,
  input  logic             frame_end,
  output logic             word_v,
  output logic [15:0]      word,
  output logic             db_we,
  output logic [DB_AW-1:0] db_addr,
  output logic [15:0]      db_data,
  output logic             ss_we,
  output logic [SS_AW-1:0] ss_addr,
  output logic [7:0]       ss_data
);
  logic [7:0]       hi_q;
  logic             hi_v;
  logic [DB_AW-1:0] wptr;
  logic [SS_AW-1:0] ss_idx;
  logic             ss_stop;
  logic             ss_take, idx_full, data_byte;

  assign data_byte = pay_valid && (pay_mode == PM_DATA);
  assign word_v    = data_byte && !pay_msb && hi_v;
  assign word      = {hi_q, pay_data};
  assign ss_take   = pay_valid && (pay_mode == PM_SSTR) && !ss_stop;
  assign idx_full  = (ss_idx == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      hi_v <= 1'b0;
      wptr <= '0;
      db_we <= 1'b0;
      db_addr <= '0;
      db_data <= '0;
    end else begin
      db_we <= word_v;
      if (word_v) begin
        db_addr <= wptr;
        db_data <= word;
      end
      if (hdr_fire && hdr_cmd == CMD_RST) wptr <= '0;
      else if (word_v)                    wptr <= wptr + 1'b1;
      if (data_byte && pay_msb) hi_q <= pay_data;
      if (frame_end)              hi_v <= 1'b0;
      else if (data_byte)         hi_v <= pay_msb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_idx  <= '0;
      ss_stop <= 1'b1;
      ss_we   <= 1'b0;
      ss_addr <= '0;
      ss_data <= '0;
    end else begin
      ss_we <= ss_take;
      if (hdr_fire && hdr_cmd == CMD_SSTR) begin
        ss_idx  <= '0;
        ss_stop <= 1'b0;
      end else if (ss_take) begin
        ss_addr <= ss_idx;
        ss_data <= idx_full ? 8'h00 : pay_data;
        ss_stop <= idx_full || (pay_data == 8'h00);
        ss_idx  <= ss_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser import cfp_pkg::*; #(
  parameter int FRAME_LEN = 1024,
  parameter int DB_AW     = 16,
  parameter int SS_AW     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_good,
  output logic             rst_pulse,
  output logic             ck_req,
  output logic [15:0]      ck_value,
  output logic             go_pulse,
  output logic             ss_we,
  output logic [SS_AW-1:0] ss_addr,
  output logic [7:0]       ss_data,
  output logic             db_we,
  output logic [DB_AW-1:0] db_addr,
  output logic [15:0]      db_data
);
  logic      hdr_fire, pay_valid, pay_msb, frame_end, word_v;
  cmd_t      hdr_cmd;
  pay_mode_t pay_mode;
  logic [15:0] word, sum;

  cfp_hdr #(.FRAME_LEN(FRAME_LEN)) u_hdr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_good(in_good), .hdr_fire(hdr_fire),
    .hdr_cmd(hdr_cmd), .pay_valid(pay_valid), .pay_msb(pay_msb),
    .pay_mode(pay_mode), .frame_end(frame_end)
  );

  cfp_pay #(.DB_AW(DB_AW), .SS_AW(SS_AW)) u_pay (
    .clk(clk), .rst(rst), .hdr_fire(hdr_fire), .hdr_cmd(hdr_cmd),
    .pay_valid(pay_valid), .pay_msb(pay_msb), .pay_data(in_data),
    .pay_mode(pay_mode), .frame_end(frame_end), .word_v(word_v),
    .word(word), .db_we(db_we), .db_addr(db_addr), .db_data(db_data),
    .ss_we(ss_we), .ss_addr(ss_addr), .ss_data(ss_data)
  );

  cfp_sum #(.W(16)) u_sum (
    .clk(clk), .rst(rst), .clr(hdr_fire && hdr_cmd == CMD_RST),
    .word_v(word_v), .word(word), .sum(sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pulse <= 1'b0;
      ck_req    <= 1'b0;
      go_pulse  <= 1'b0;
      ck_value  <= '0;
    end else begin
      rst_pulse <= hdr_fire && (hdr_cmd == CMD_RST);
      ck_req    <= hdr_fire && (hdr_cmd == CMD_CKREP);
      go_pulse  <= hdr_fire && (hdr_cmd == CMD_GO);
      if (hdr_fire && hdr_cmd == CMD_CKREP) ck_value <= sum;
    end
  end
endmodule

// File: rtl/cfp_chk.sv
module cfp_chk #(
  parameter int DB_AW = 16,
  parameter int SS_AW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_pulse,
  input logic             ck_req,
  input logic [15:0]      ck_value,
  input logic             go_pulse,
  input logic             ss_we,
  input logic [SS_AW-1:0] ss_addr,
  input logic [7:0]       ss_data,
  input logic             db_we,
  input logic [DB_AW-1:0] db_addr
);
  logic [DB_AW-1:0] exp_addr;
  always_ff @(posedge clk) begin
    if (rst || rst_pulse) exp_addr <= '0;
    else if (db_we)       exp_addr <= db_addr + 1'b1;
  end

  // R7
  db_seq_chk: assert property (@(posedge clk) disable iff (rst)
    db_we |-> db_addr == exp_addr);

  // R6
  ss_term_chk: assert property (@(posedge clk) disable iff (rst)
    (ss_we && ss_addr == '1) |-> ss_data == 8'h00);

  // R1
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({db_we, ss_we, rst_pulse, ck_req, go_pulse}));

  // R2
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);

  // R3
  ck_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ck_req |-> $stable(ck_value));
endmodule

bind cmd_frame_parser cfp_chk #(.DB_AW(DB_AW), .SS_AW(SS_AW)) u_chk (
  .clk(clk), .rst(rst), .rst_pulse(rst_pulse), .ck_req(ck_req),
  .ck_value(ck_value), .go_pulse(go_pulse), .ss_we(ss_we),
  .ss_addr(ss_addr), .ss_data(ss_data), .db_we(db_we), .db_addr(db_addr)
);

// File: tb/cmd_frame_parser_test.sv
`timescale 1ns/1ps
module cmd_frame_parser_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, in_good = 1'b0;
  logic [7:0] in_data = '0;
  logic rst_pulse, ck_req, go_pulse, ss_we, db_we;
  logic [15:0] ck_value, db_addr, db_data;
  logic [7:0] ss_addr, ss_data;

  always #2 clk = ~clk;

  cmd_frame_parser uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_good(in_good), .rst_pulse(rst_pulse),
    .ck_req(ck_req), .ck_value(ck_value), .go_pulse(go_pulse),
    .ss_we(ss_we), .ss_addr(ss_addr), .ss_data(ss_data),
    .db_we(db_we), .db_addr(db_addr), .db_data(db_data)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int db_qa[$], db_qd[$], ss_qa[$], ss_qd[$], ev_qk[$], ev_qv[$];
  int exp_wptr = 0;
  int exp_sum  = 0;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: events are 0 reset, 1 checksum report, 2 go
  always @(negedge clk) begin
    if (!rst) begin
      if (db_we) begin
        if (db_qa.size() == 0) chk("R1/R8/R9 unexpected db write", db_addr, -1);
        else begin
          chk("R7 db address", db_addr, db_qa.pop_front());
          chk("R7 db word", db_data, db_qd.pop_front());
        end
      end
      if (ss_we) begin
        if (ss_qa.size() == 0) chk("R5 unexpected ss write", ss_addr, -1);
        else begin
          chk("R5 ss address", ss_addr, ss_qa.pop_front());
          chk("R5/R6 ss byte", ss_data, ss_qd.pop_front());
        end
      end
      if (rst_pulse || ck_req || go_pulse) begin
        int k;
        k = rst_pulse ? 0 : (ck_req ? 1 : 2);
        if (ev_qk.size() == 0) chk("R1 unexpected pulse", k, -1);
        else begin
          chk("R2/R3/R4 pulse kind", k, ev_qk.pop_front());
          if (k == 1) chk("R3 checksum value", ck_value, ev_qv.pop_front());
          else void'(ev_qv.pop_front());
        end
      end
    end
  end

  function automatic logic [7:0] fbyte(int k, logic [15:0] typ, logic [15:0] proto,
                                       bit bc, int seed, int pk);
    int off;
    off = k - 14;
    if (k < 6)   return (bc || k != 3) ? 8'hFF : 8'h02;
    if (k < 10)  return 8'h55;
    if (k == 10) return typ[15:8];
    if (k == 11) return typ[7:0];
    if (k == 12) return proto[15:8];
    if (k == 13) return proto[7:0];
    if (k >= 1024) return 8'hEE;
    if (pk == 1) begin
      case (off)
        0: return 8'h43;
        1: return 8'h41;
        2: return 8'h42;
        3: return 8'h00;
        default: return 8'h51;
      endcase
    end
    if (pk == 2) return 8'h41;
    return 8'(seed * 29 + k * 7 + (k >> 4));
  endfunction

  task automatic send_frame(string tag, logic [15:0] typ, logic [15:0] proto,
                            bit bc, bit good, int len, int seed, int pk);
    bit acc;
    int plen;
    acc  = good && bc && (proto == 16'h8000) && (len >= 14);
    plen = (len < 1024) ? len : 1024;
    if (acc) begin
      case (typ)
        16'h0000: begin ev_qk.push_back(0); ev_qv.push_back(0); exp_wptr = 0; exp_sum = 0; end
        16'hAAAA: begin ev_qk.push_back(1); ev_qv.push_back(exp_sum); end
        16'hCCCC: begin ev_qk.push_back(2); ev_qv.push_back(0); end
        16'hBBBB: begin
          int idx;
          bit stop;
          idx = 0; stop = 0;
          for (int k = 14; k < plen && !stop; k++) begin
            logic [7:0] b;
            b = fbyte(k, typ, proto, bc, seed, pk);
            ss_qa.push_back(idx);
            ss_qd.push_back(idx == 255 ? 0 : int'(b));
            if (b == 0 || idx == 255) stop = 1;
            idx++;
          end
        end
        default: begin
          for (int k = 14; k + 1 < plen; k += 2) begin
            int w;
            w = {16'h0, fbyte(k, typ, proto, bc, seed, pk), fbyte(k+1, typ, proto, bc, seed, pk)};
            db_qa.push_back(exp_wptr);
            db_qd.push_back(w);
            exp_wptr = (exp_wptr + 1) & 16'hFFFF;
            exp_sum  = (exp_sum + w) & 16'hFFFF;
          end
        end
      endcase
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fbyte(k, typ, proto, bc, seed, pk);
      in_last  = (k == len - 1);
      in_good  = good;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (4) @(negedge clk);
    chk({tag, " pending db writes"}, db_qa.size(), 0);
    chk({tag, " pending ss writes"}, ss_qa.size(), 0);
    chk({tag, " pending pulses"}, ev_qk.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 strobes idle after reset", {rst_pulse, ck_req, go_pulse, ss_we, db_we}, 0);
    chk("R10 ck_value after reset", ck_value, 0);
    send_frame("R3 initial report", 16'hAAAA, 16'h8000, 1, 1, 1028, 0, 0);
    send_frame("R7 R10 first data frame", 16'h1234, 16'h8000, 1, 1, 1028, 1, 0);
    send_frame("R7 R8 second data frame", 16'h5A5A, 16'h8000, 1, 1, 1028, 2, 0);
    send_frame("R3 report after data", 16'hAAAA, 16'h8000, 1, 1, 1028, 0, 0);
    send_frame("R9 bad frame", 16'h7777, 16'h8000, 1, 0, 1028, 3, 0);
    send_frame("R1 wrong protocol", 16'h7777, 16'h8001, 1, 1, 1028, 4, 0);
    send_frame("R1 non-broadcast", 16'hAAAA, 16'h8000, 0, 1, 1028, 5, 0);
    send_frame("R1 short frame", 16'h0000, 16'h8000, 1, 1, 12, 6, 0);
    send_frame("R9 R3 report unchanged", 16'hAAAA, 16'h8000, 1, 1, 1028, 0, 0);
    send_frame("R5 terminated string", 16'hBBBB, 16'h8000, 1, 1, 1028, 0, 1);
    send_frame("R6 unterminated string", 16'hBBBB, 16'h8000, 1, 1, 1028, 0, 2);
    send_frame("R4 go command", 16'hCCCC, 16'h8000, 1, 1, 1028, 7, 0);
    send_frame("R8 odd short data frame", 16'h0101, 16'h8000, 1, 1, 19, 8, 0);
    send_frame("R2 reset command", 16'h0000, 16'h8000, 1, 1, 1028, 9, 0);
    send_frame("R2 R3 report after reset", 16'hAAAA, 16'h8000, 1, 1, 1028, 0, 0);
    send_frame("R2 R7 data after reset", 16'hFFFF, 16'h8000, 1, 1, 1028, 10, 0);
    send_frame("R3 final report", 16'hAAAA, 16'h8000, 1, 1, 1028, 0, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule